// File: doc/BRIEF.md
# Configurable Parallel Character Interface Stage

This block sits between a host's parallel buses and the character pipeline of a serial link. On the transmit side it takes a character from either a data bus or a command bus, as chosen by a select input. It packs that character into one internal word. The width and layout of that word are set by two static mode pins: one chooses between the narrow and the wide character size, the other says whether the line encoder is in use or bypassed. Captured words go through a small transmit queue, or straight through when the queue is bypassed. A consumer on the core side pulls them out.

A third static pin selects external-FIFO mode, which changes three things together. The transmit enable becomes active low and the bus is sampled one clock after the enable. The full and empty flags become active high. The half-full flag stays active low in every mode. On the receive side the block does the reverse: it splits an internal word onto the data and command outputs, and marks which kind it was when the encoder is in use. All four mode pins are captured only while reset is held.

Top module: `char_if_stage`

## Requirements
- R1: Narrow size with encoder on: a data character puts tx_data_i[7:0] in word bits [7:0]; a command puts tx_cmd_i[3:0] in bits [3:0] and raises the command flag; all other word bits are 0.
- R2: Narrow size with encoder bypassed: the word carries tx_data_i[9:0] in bits [9:0] with bits [11:10] zero and the command flag 0, whatever the select input says.
- R3: Wide size with encoder on: a data character fills word bits [9:0] from tx_data_i; a command puts tx_cmd_i[1:0] in bits [1:0] and raises the command flag; other bits are 0.
- R4: Wide size with encoder bypassed: the word is {tx_cmd_i[1:0], tx_data_i[9:0]} with the command flag 0, whatever the select input says.
- R5: The receive side registers one word per valid strobe and presents it one clock later. With the encoder on, data goes to rx_data_o and command to rx_cmd_o, with rx_is_cmd_o marking which. Narrow raw mode puts bits [9:0] on rx_data_o. Wide raw mode puts bits [9:0] on rx_data_o and bits [11:10] on rx_cmd_o[1:0]. Unused output bits are 0, and rx_is_cmd_o is 0 in raw modes.
- R6: In external-FIFO mode tx_full_o and tx_empty_o are active high; otherwise they are active low; tx_half_o is active low in both modes.
- R7: Outside external-FIFO mode tx_en_i is active high and the bus is captured on the edge that samples it. In external-FIFO mode tx_en_i is active low and the bus is captured on the following edge. An inactive enable captures nothing.
- R8: With the queue in use, words leave in write order. tx_rd_i pops one, which appears on tx_char_o with a tx_char_vld_o pulse one clock later.
- R9: The half-full flag is active when DEPTH/2 or more words are held; the full flag is active at DEPTH words.
- R10: A capture while full is dropped and sets tx_ovf_o, which stays set until reset.
- R11: A pop while empty gives no valid pulse and leaves tx_char_o and the pointers unchanged.
- R12: With the queue bypassed, a captured word appears on tx_char_o with a valid pulse one clock after its capture edge. The flags show an empty queue, and tx_rd_i has no effect.
- R13: The four mode pins are sampled only while rst_n is low; changes after reset do not alter packing, flags or queue use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; mode pins sampled while low |
| size8_i | input | 1 | 1 = narrow character size, 0 = wide |
| enc_on_i | input | 1 | 1 = encoder in use, 0 = raw characters |
| ext_fifo_i | input | 1 | 1 = external-FIFO mode |
| fifo_skip_i | input | 1 | 1 = transmit queue bypassed |
| tx_en_i | input | 1 | Transmit enable, polarity per mode |
| tx_sel_cmd_i | input | 1 | 1 = capture command bus, 0 = data bus |
| tx_data_i | input | DATA_W | Transmit data bus |
| tx_cmd_i | input | CMD_W | Transmit command bus |
| tx_rd_i | input | 1 | Core-side pop request |
| tx_char_o | output | DATA_W+CMD_W-2 | Packed word toward the encoder |
| tx_char_cmd_o | output | 1 | Command flag of tx_char_o |
| tx_char_vld_o | output | 1 | One-clock valid pulse for tx_char_o |
| tx_full_o | output | 1 | Full flag, polarity per mode |
| tx_empty_o | output | 1 | Empty flag, polarity per mode |
| tx_half_o | output | 1 | Half-full flag, active low |
| tx_ovf_o | output | 1 | Sticky overflow, active high |
| rx_char_i | input | DATA_W+CMD_W-2 | Received word from the decoder |
| rx_char_cmd_i | input | 1 | Command flag of rx_char_i |
| rx_char_vld_i | input | 1 | Valid strobe for rx_char_i |
| rx_data_o | output | DATA_W | Received data |
| rx_cmd_o | output | CMD_W | Received command |
| rx_is_cmd_o | output | 1 | 1 = presented character is a command |
| rx_vld_o | output | 1 | Valid pulse for receive outputs |

## Verification
The bench keeps the default bus widths (10-bit data, 4-bit command, 12-bit word) so that all four packing formats are exercised at their true field positions. It builds the block with DEPTH set to 8, which brings the half-full threshold (4) and the full and overflow boundary within a few writes. It therefore also covers the drain to empty and the pop on an empty queue. Each mode is entered through a fresh reset, and pin changes after reset then show that the latched mode holds.

// File: rtl/char_if_pkg.sv
package char_if_pkg;

   typedef struct packed {
      logic byte_mode;
      logic enc_on;
      logic ext_fifo;
      logic fifo_skip;
   } mode_t;

   typedef enum logic [1:0] {
      FMT_N_ENC = 2'd0,
      FMT_N_RAW = 2'd1,
      FMT_W_ENC = 2'd2,
      FMT_W_RAW = 2'd3
   } fmt_e;

   function automatic fmt_e fmt_of(input mode_t m);
      case ({m.byte_mode, m.enc_on})
         2'b11:   return FMT_N_ENC;
         2'b10:   return FMT_N_RAW;
         2'b01:   return FMT_W_ENC;
         default: return FMT_W_RAW;
      endcase
   endfunction

endpackage

// File: rtl/char_if_pack.sv
module char_if_pack
   import char_if_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int CMD_W  = 4,
   localparam int WCMD   = CMD_W - 2,
   localparam int NDATA  = DATA_W - 2,
   localparam int CHAR_W = DATA_W + WCMD
) (
   input  fmt_e              fmt,
   input  logic              sel_cmd,
   input  logic [DATA_W-1:0] data,
   input  logic [CMD_W-1:0]  cmd,
   output logic [CHAR_W-1:0] word_o,
   output logic              is_cmd_o
);

   always_comb begin
      word_o   = '0;
      is_cmd_o = 1'b0;
      case (fmt)
         FMT_N_ENC: begin
            if (sel_cmd) begin
               word_o[CMD_W-1:0] = cmd;
               is_cmd_o          = 1'b1;
            end else begin
               word_o[NDATA-1:0] = data[NDATA-1:0];
            end
         end
         FMT_N_RAW: word_o[DATA_W-1:0] = data;
         FMT_W_ENC: begin
            if (sel_cmd) begin
               word_o[WCMD-1:0] = cmd[WCMD-1:0];
               is_cmd_o         = 1'b1;
            end else begin
               word_o[DATA_W-1:0] = data;
            end
         end
         default: word_o = {cmd[WCMD-1:0], data};
      endcase
   end

endmodule

// File: rtl/char_if_txq.sv
module char_if_txq #(
   parameter int W     = 13,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         skip,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic         rd_i,
   output logic [W-1:0] q_o,
   output logic         q_vld_o,
   output logic         full_o,
   output logic         empty_o,
   output logic         half_o,
   output logic         ovf_o
);

   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          do_wr, do_rd;
   logic [W-1:0]  rd_view [DEPTH];

   assign full_o  = (cnt == CW'(DEPTH));
   assign empty_o = (cnt == '0);
   assign half_o  = (cnt >= CW'(DEPTH / 2));
   assign do_wr   = wr_i && !full_o && !skip;
   assign do_rd   = rd_i && !empty_o && !skip;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [W-1:0] slot;
      always_ff @(posedge clk) begin
         if (do_wr && (wptr == AW'(i))) slot <= wdata_i;
      end
      assign rd_view[i] = slot;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         cnt     <= '0;
         ovf_o   <= 1'b0;
         q_vld_o <= 1'b0;
         q_o     <= '0;
      end else if (skip) begin
         q_vld_o <= wr_i;
         if (wr_i) q_o <= wdata_i;
      end else begin
         q_vld_o <= do_rd;
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) begin
            rptr <= rptr + 1'b1;
            q_o  <= rd_view[rptr];
         end
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (wr_i && full_o) ovf_o <= 1'b1;
      end
   end

endmodule

// File: rtl/char_if_unpack.sv
module char_if_unpack
   import char_if_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int CMD_W  = 4,
   localparam int WCMD   = CMD_W - 2,
   localparam int NDATA  = DATA_W - 2,
   localparam int CHAR_W = DATA_W + WCMD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fmt_e              fmt,
   input  logic [CHAR_W-1:0] word_i,
   input  logic              is_cmd_i,
   input  logic              vld_i,
   output logic [DATA_W-1:0] data_o,
   output logic [CMD_W-1:0]  cmd_o,
   output logic              is_cmd_o,
   output logic              vld_o
);

   logic [DATA_W-1:0] data_n;
   logic [CMD_W-1:0]  cmd_n;
   logic              isc_n;

   always_comb begin
      data_n = '0;
      cmd_n  = '0;
      isc_n  = 1'b0;
      case (fmt)
         FMT_N_ENC: begin
            isc_n = is_cmd_i;
            if (is_cmd_i) cmd_n = word_i[CMD_W-1:0];
            else          data_n[NDATA-1:0] = word_i[NDATA-1:0];
         end
         FMT_N_RAW: data_n = word_i[DATA_W-1:0];
         FMT_W_ENC: begin
            isc_n = is_cmd_i;
            if (is_cmd_i) cmd_n[WCMD-1:0] = word_i[WCMD-1:0];
            else          data_n = word_i[DATA_W-1:0];
         end
         default: begin
            data_n          = word_i[DATA_W-1:0];
            cmd_n[WCMD-1:0] = word_i[CHAR_W-1:DATA_W];
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_o   <= '0;
         cmd_o    <= '0;
         is_cmd_o <= 1'b0;
         vld_o    <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            data_o   <= data_n;
            cmd_o    <= cmd_n;
            is_cmd_o <= isc_n;
         end
      end
   end

endmodule

// File: rtl/char_if_stage.sv
module char_if_stage
   import char_if_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int CMD_W  = 4,
   parameter int DEPTH  = 16,
   localparam int CHAR_W = DATA_W + CMD_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              size8_i,
   input  logic              enc_on_i,
   input  logic              ext_fifo_i,
   input  logic              fifo_skip_i,
   input  logic              tx_en_i,
   input  logic              tx_sel_cmd_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic [CMD_W-1:0]  tx_cmd_i,
   input  logic              tx_rd_i,
   output logic [CHAR_W-1:0] tx_char_o,
   output logic              tx_char_cmd_o,
   output logic              tx_char_vld_o,
   output logic              tx_full_o,
   output logic              tx_empty_o,
   output logic              tx_half_o,
   output logic              tx_ovf_o,
   input  logic [CHAR_W-1:0] rx_char_i,
   input  logic              rx_char_cmd_i,
   input  logic              rx_char_vld_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic [CMD_W-1:0]  rx_cmd_o,
   output logic              rx_is_cmd_o,
   output logic              rx_vld_o
);

   localparam int QW = CHAR_W + 1;

   if (CMD_W < 3) begin : g_bad_cmd
      $error("CMD_W must be at least 3");
   end
   if (DATA_W <= CMD_W) begin : g_bad_data
      $error("DATA_W must exceed CMD_W");
   end
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 4");
   end

   mode_t mode_q;
   fmt_e  fmt;
   logic  en_act, en_q, cap;
   logic [CHAR_W-1:0] pk_word;
   logic              pk_cmd;
   logic [QW-1:0]     q_word;
   logic q_full, q_empty, q_half;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '{byte_mode: size8_i, enc_on: enc_on_i,
                     ext_fifo: ext_fifo_i, fifo_skip: fifo_skip_i};
      end
   end

   assign fmt = fmt_of(mode_q);

   assign en_act = mode_q.ext_fifo ? !tx_en_i : tx_en_i;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_act;
   end

   assign cap = mode_q.ext_fifo ? en_q : en_act;

   char_if_pack #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_pack (
      .fmt      (fmt),
      .sel_cmd  (tx_sel_cmd_i),
      .data     (tx_data_i),
      .cmd      (tx_cmd_i),
      .word_o   (pk_word),
      .is_cmd_o (pk_cmd)
   );

   char_if_txq #(.W(QW), .DEPTH(DEPTH)) u_txq (
      .clk     (clk),
      .rst_n   (rst_n),
      .skip    (mode_q.fifo_skip),
      .wr_i    (cap),
      .wdata_i ({pk_cmd, pk_word}),
      .rd_i    (tx_rd_i),
      .q_o     (q_word),
      .q_vld_o (tx_char_vld_o),
      .full_o  (q_full),
      .empty_o (q_empty),
      .half_o  (q_half),
      .ovf_o   (tx_ovf_o)
   );

   assign {tx_char_cmd_o, tx_char_o} = q_word;
   assign tx_full_o  = mode_q.ext_fifo ? q_full  : !q_full;
   assign tx_empty_o = mode_q.ext_fifo ? q_empty : !q_empty;
   assign tx_half_o  = !q_half;

   char_if_unpack #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_unpack (
      .clk      (clk),
      .rst_n    (rst_n),
      .fmt      (fmt),
      .word_i   (rx_char_i),
      .is_cmd_i (rx_char_cmd_i),
      .vld_i    (rx_char_vld_i),
      .data_o   (rx_data_o),
      .cmd_o    (rx_cmd_o),
      .is_cmd_o (rx_is_cmd_o),
      .vld_o    (rx_vld_o)
   );

endmodule

// File: rtl/char_if_stage_chk.sv
module char_if_stage_chk
   import char_if_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input mode_t mode,
   input logic  tx_full_o,
   input logic  tx_empty_o,
   input logic  tx_half_o,
   input logic  tx_ovf_o,
   input logic  tx_rd_i,
   input logic  tx_char_vld_o,
   input logic  tx_char_cmd_o,
   input logic  rx_char_vld_i,
   input logic  rx_vld_o
);

   logic f_act, e_act, h_act;
   assign f_act = mode.ext_fifo ? tx_full_o  : !tx_full_o;
   assign e_act = mode.ext_fifo ? tx_empty_o : !tx_empty_o;
   assign h_act = !tx_half_o;

   // R6
   full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(f_act && e_act));

   // R9
   full_implies_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      f_act |-> h_act);

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ovf_o |=> tx_ovf_o);

   // R12
   skip_flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode.fifo_skip |-> (e_act && !f_act && !h_act && !tx_ovf_o));

   // R8
   pop_before_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode.fifo_skip && tx_char_vld_o) |-> $past(tx_rd_i));

   // R11
   empty_pop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode.fifo_skip && e_act && tx_rd_i) |=> !tx_char_vld_o);

   // R2
   raw_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode.enc_on && tx_char_vld_o) |-> !tx_char_cmd_o);

   // R5
   rx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_char_vld_i |=> rx_vld_o);

   // R13
   mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(mode));

endmodule

bind char_if_stage char_if_stage_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mode          (mode_q),
   .tx_full_o     (tx_full_o),
   .tx_empty_o    (tx_empty_o),
   .tx_half_o     (tx_half_o),
   .tx_ovf_o      (tx_ovf_o),
   .tx_rd_i       (tx_rd_i),
   .tx_char_vld_o (tx_char_vld_o),
   .tx_char_cmd_o (tx_char_cmd_o),
   .rx_char_vld_i (rx_char_vld_i),
   .rx_vld_o      (rx_vld_o)
);

// File: tb/tb_char_if_stage.sv
module tb_char_if_stage;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic size8 = 1'b1, enc_on = 1'b1, ext_fifo = 1'b0, fifo_skip = 1'b0;
   logic tx_en = 1'b0, tx_sel = 1'b0, tx_rd = 1'b0;
   logic [9:0]  tx_data = '0;
   logic [3:0]  tx_cmd = '0;
   logic [11:0] tx_char;
   logic tx_char_cmd, tx_char_vld, tx_full, tx_empty, tx_half, tx_ovf;
   logic [11:0] rx_char = '0;
   logic rx_char_cmd = 1'b0, rx_char_vld = 1'b0;
   logic [9:0] rx_data;
   logic [3:0] rx_cmd;
   logic rx_is_cmd, rx_vld;

   int n_chk = 0, n_err = 0;
   bit m_s8, m_enc, m_ext;
   string tx_tag = "R1", rx_tag = "R5";
   logic [12:0] tx_q [$];
   logic [14:0] rx_q [$];

   always #2 clk = !clk;

   char_if_stage #(.DEPTH(8)) dut (
      .clk(clk), .rst_n(rst_n), .size8_i(size8), .enc_on_i(enc_on),
      .ext_fifo_i(ext_fifo), .fifo_skip_i(fifo_skip), .tx_en_i(tx_en),
      .tx_sel_cmd_i(tx_sel), .tx_data_i(tx_data), .tx_cmd_i(tx_cmd),
      .tx_rd_i(tx_rd), .tx_char_o(tx_char), .tx_char_cmd_o(tx_char_cmd),
      .tx_char_vld_o(tx_char_vld), .tx_full_o(tx_full), .tx_empty_o(tx_empty),
      .tx_half_o(tx_half), .tx_ovf_o(tx_ovf), .rx_char_i(rx_char),
      .rx_char_cmd_i(rx_char_cmd), .rx_char_vld_i(rx_char_vld),
      .rx_data_o(rx_data), .rx_cmd_o(rx_cmd), .rx_is_cmd_o(rx_is_cmd),
      .rx_vld_o(rx_vld)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [12:0] ref_pack(bit s8, bit enc, bit sel,
                                            logic [9:0] d, logic [3:0] c);
      if (s8 && enc)  return sel ? {1'b1, 8'h00, c} : {1'b0, 4'h0, d[7:0]};
      if (s8)         return {3'b000, d};
      if (enc)        return sel ? {1'b1, 10'h000, c[1:0]} : {3'b000, d};
      return {1'b0, c[1:0], d};
   endfunction

   function automatic logic [14:0] ref_unpack(bit s8, bit enc,
                                              logic [11:0] w, bit f);
      if (s8 && enc)  return f ? {1'b1, w[3:0], 10'h000} : {1'b0, 4'h0, 2'b00, w[7:0]};
      if (s8)         return {1'b0, 4'h0, w[9:0]};
      if (enc)        return f ? {1'b1, 2'b00, w[1:0], 10'h000} : {1'b0, 4'h0, w[9:0]};
      return {1'b0, 2'b00, w[11:10], w[9:0]};
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && tx_char_vld) begin
         if (tx_q.size() == 0) chk(1'b0, {tx_tag, " unexpected tx valid"}, {19'h0, tx_char_cmd, tx_char}, 32'h0);
         else begin
            logic [12:0] e;
            e = tx_q.pop_front();
            chk({tx_char_cmd, tx_char} == e, tx_tag, {19'h0, tx_char_cmd, tx_char}, {19'h0, e});
         end
      end
      if (rst_n && rx_vld) begin
         if (rx_q.size() == 0) chk(1'b0, {rx_tag, " unexpected rx valid"}, {17'h0, rx_is_cmd, rx_cmd, rx_data}, 32'h0);
         else begin
            logic [14:0] e;
            e = rx_q.pop_front();
            chk({rx_is_cmd, rx_cmd, rx_data} == e, rx_tag, {17'h0, rx_is_cmd, rx_cmd, rx_data}, {17'h0, e});
         end
      end
   end

   task automatic do_reset(bit s8, bit enc, bit ext, bit skip);
      @(negedge clk);
      rst_n = 1'b0;
      size8 = s8; enc_on = enc; ext_fifo = ext; fifo_skip = skip;
      tx_en = ext; tx_rd = 1'b0; rx_char_vld = 1'b0;
      m_s8 = s8; m_enc = enc; m_ext = ext;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic tx_send(bit sel, logic [9:0] d, logic [3:0] c, bit push);
      if (push) tx_q.push_back(ref_pack(m_s8, m_enc, sel, d, c));
      if (m_ext) begin
         @(negedge clk);
         tx_en = 1'b0; tx_sel = !sel; tx_data = ~d; tx_cmd = ~c;
         @(negedge clk);
         tx_en = 1'b1; tx_sel = sel; tx_data = d; tx_cmd = c;
         @(negedge clk);
      end else begin
         @(negedge clk);
         tx_en = 1'b1; tx_sel = sel; tx_data = d; tx_cmd = c;
         @(negedge clk);
         tx_en = 1'b0; tx_data = ~d; tx_cmd = ~c;
      end
   endtask

   task automatic tx_pop();
      @(negedge clk); tx_rd = 1'b1;
      @(negedge clk); tx_rd = 1'b0;
   endtask

   task automatic rx_send(logic [11:0] w, bit f);
      rx_q.push_back(ref_unpack(m_s8, m_enc, w, f));
      @(negedge clk); rx_char = w; rx_char_cmd = f; rx_char_vld = 1'b1;
      @(negedge clk); rx_char_vld = 1'b0; rx_char = ~w;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk(1'b0, "timeout", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : main
      // narrow, encoder on, queue in use, normal flags
      do_reset(1'b1, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      chk(tx_full == 1'b1 && tx_empty == 1'b0 && tx_half == 1'b1, "R6 reset flags low-active",
          {tx_full, tx_empty, tx_half}, 3'b101);
      chk(tx_ovf == 1'b0 && tx_char_vld == 1'b0, "R10 reset ovf", {tx_ovf, tx_char_vld}, 0);
      tx_tag = "R1";
      tx_send(1'b0, 10'h3A5, 4'h2, 1'b1);
      tx_send(1'b1, 10'h155, 4'h9, 1'b1);
      tx_send(1'b0, 10'h0FF, 4'hF, 1'b1);
      tx_tag = "R8";
      repeat (3) tx_pop();
      @(negedge clk);
      chk(tx_q.size() == 0, "R8 drained", tx_q.size(), 0);
      rx_tag = "R5 narrow enc";
      rx_send(12'hFA5, 1'b0);
      rx_send(12'hFF6, 1'b1);

      // fill to the boundary
      tx_tag = "R9";
      for (int i = 0; i < 8; i++) begin
         tx_send(1'b0, 10'(8'h10 + i), 4'h0, 1'b1);
         if (i == 2) chk(tx_half == 1'b1, "R9 half inactive at 3", tx_half, 1);
         if (i == 3) chk(tx_half == 1'b0, "R9 half active at 4", tx_half, 0);
         if (i == 6) chk(tx_full == 1'b1, "R9 not full at 7", tx_full, 1);
      end
      chk(tx_full == 1'b0, "R9 full at DEPTH", tx_full, 0);
      tx_send(1'b0, 10'h0EE, 4'h0, 1'b0);
      chk(tx_ovf == 1'b1, "R10 overflow set", tx_ovf, 1);
      tx_tag = "R10";
      repeat (8) tx_pop();
      @(negedge clk);
      chk(tx_empty == 1'b0 && tx_full == 1'b1, "R6 empty active low", {tx_full, tx_empty}, 2'b10);
      chk(tx_ovf == 1'b1, "R10 overflow sticky", tx_ovf, 1);
      tx_tag = "R11";
      tx_pop();
      @(negedge clk);
      chk(tx_char_vld == 1'b0 && tx_char == 12'h017, "R11 empty pop holds",
          {tx_char_vld, tx_char}, 13'h0017);

      // wide, encoder on, external-FIFO mode
      do_reset(1'b0, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      chk(tx_full == 1'b0 && tx_empty == 1'b1 && tx_half == 1'b1, "R6 ext flags",
          {tx_full, tx_empty, tx_half}, 3'b011);
      tx_sel = 1'b0; tx_data = 10'h123;
      repeat (5) @(negedge clk);
      chk(tx_empty == 1'b1, "R7 idle enable captures nothing", tx_empty, 1);
      tx_tag = "R7 R3";
      tx_send(1'b0, 10'h2B7, 4'h1, 1'b1);
      chk(tx_empty == 1'b0, "R7 one captured", tx_empty, 0);
      tx_send(1'b1, 10'h000, 4'hE, 1'b1);
      repeat (2) tx_pop();
      rx_tag = "R5 wide enc";
      rx_send(12'hABC, 1'b0);
      rx_send(12'h007, 1'b1);

      // wide raw, queue bypassed
      do_reset(1'b0, 1'b0, 1'b0, 1'b1);
      tx_tag = "R4 R12";
      tx_send(1'b0, 10'h155, 4'h1, 1'b1);
      tx_send(1'b1, 10'h2AA, 4'h2, 1'b1);
      tx_pop();
      @(negedge clk);
      chk(tx_empty == 1'b0 && tx_full == 1'b1 && tx_half == 1'b1, "R12 bypass flags",
          {tx_full, tx_empty, tx_half}, 3'b101);
      rx_tag = "R5 wide raw";
      rx_send(12'hC21, 1'b1);

      // narrow raw, queue bypassed, then pins moved after reset
      do_reset(1'b1, 1'b0, 1'b0, 1'b1);
      tx_tag = "R2";
      tx_send(1'b1, 10'h3FF, 4'hF, 1'b1);
      rx_tag = "R5 narrow raw";
      rx_send(12'hFFF, 1'b1);
      size8 = 1'b0; enc_on = 1'b1; fifo_skip = 1'b0; ext_fifo = 1'b1;
      tx_tag = "R13";
      tx_send(1'b1, 10'h2C3, 4'h5, 1'b1);
      rx_tag = "R13 rx";
      rx_send(12'hE81, 1'b1);
      @(negedge clk);
      chk(tx_empty == 1'b0 && tx_full == 1'b1, "R13 flags keep latched mode",
          {tx_full, tx_empty}, 2'b10);

      repeat (4) @(negedge clk);
      chk(tx_q.size() == 0 && rx_q.size() == 0, "R8 R5 all delivered",
          tx_q.size() + rx_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule